// File: doc/BRIEF.md
# Timer interrupt flag controller

This block holds the interrupt flags and interrupt enables of a 16-bit timer/counter. The counter, its compare values and the waveform generator sit elsewhere. They feed this block with the counter value, the two compare values, one-cycle event pulses and the current waveform mode. The block latches each event into a flag. It applies a per-source enable and a global enable, and it drives one registered interrupt request per source.

Software reads both the flag register and the enable register. It clears a flag by writing a one to its bit. Taking the interrupt vector clears the flag through a per-source acknowledge input. Events count only on cycles where the timer clock-enable `tick` is high. A compare flag appears one timer tick after the counter equals the compare value. A forced-compare strobe never raises a compare flag. The waveform mode decides where the capture flag and the overflow flag take their events from.

Top module: `tmr_irq_flags`

## Requirements
- R1: After a synchronous reset, `flag_q`, `en_q` and `irq` are all zero.
- R2: The register layout is bit 0 overflow, bit 1 compare A, bit 2 compare B and bit 5 capture. In both `flag_q` and `en_q`, bits 3, 4, 6 and 7 read zero and ignore writes.
- R3: A `flag_wr` cycle clears each flag whose `wdata` bit is one and leaves flags whose bit is zero unchanged.
- R4: `ack[0]` clears the overflow flag, `ack[1]` compare A, `ack[2]` compare B and `ack[3]` the capture flag.
- R5: `irq[i]` is high one cycle after (flag AND enable AND `gie`) holds for source i, and low one cycle after it fails. The order of i is overflow, A, B, capture.
- R6: Suppose a tick samples `cnt` equal to `cmp_a` (or `cmp_b`). Then the compare flag is set at the next tick, and not at the matching tick.
- R7: A tick that carries `force_a` (or `force_b`) never leads to the matching compare flag being set, even when the counter equals the compare value.
- R8: With `wmode` in {8, 10, 12, 14} the capture flag is set by `top_pulse`, and `cap_pulse` is ignored. In every other mode it is set by `cap_pulse`, and `top_pulse` is ignored.
- R9: With `wmode` in {0, 4, 12} the overflow flag is set by `ovf_pulse`. In every other mode it is set by `wave_ovf_pulse`. The pulse that does not apply is ignored.
- R10: If an event sets a flag in the same cycle as a clearing write or acknowledge for that flag, the flag ends up set.
- R11: Event pulses and compare matches arriving while `tick` is low set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock-enable qualifying all events |
| cnt | input | 16 | Current counter value |
| cmp_a | input | 16 | Compare value, channel A |
| cmp_b | input | 16 | Compare value, channel B |
| force_a | input | 1 | Forced-compare strobe, channel A |
| force_b | input | 1 | Forced-compare strobe, channel B |
| ovf_pulse | input | 1 | Counter wrap pulse (plain modes) |
| wave_ovf_pulse | input | 1 | Overflow condition from waveform logic (other modes) |
| cap_pulse | input | 1 | Input capture event |
| top_pulse | input | 1 | Counter reached TOP |
| wmode | input | 4 | Waveform mode field |
| gie | input | 1 | Global interrupt enable |
| ack | input | 4 | Vector-taken acknowledge per source |
| flag_wr | input | 1 | Write strobe for the flag register (write-one-to-clear) |
| en_wr | input | 1 | Write strobe for the enable register |
| wdata | input | 8 | Write data |
| flag_q | output | 8 | Flag register |
| en_q | output | 8 | Enable register |
| irq | output | 4 | Interrupt requests: overflow, A, B, capture |

## Verification
Overflow and capture flags are due at the first clock edge that samples the event with `tick` high. Compare flags are due one tick later, and each `irq` bit follows its flag by one more edge. The bench drives inputs one time unit after a rising edge and samples one time unit after the edge it is counting toward. Each check is placed exactly where that latency puts it. The R6 check also samples once before the due edge, which proves the flag is not early.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int REG_W  = 8;
  localparam int NSRC   = 4;
  localparam int MODE_W = 4;

  typedef enum int unsigned {
    SRC_OVF  = 0,
    SRC_CMPA = 1,
    SRC_CMPB = 2,
    SRC_CAP  = 3
  } src_e;

  localparam logic [REG_W-1:0] LIVE_MASK = 8'h27;

  function automatic int src_pos(input int s);
    case (s)
      SRC_OVF:  return 0;
      SRC_CMPA: return 1;
      SRC_CMPB: return 2;
      default:  return 5;
    endcase
  endfunction

  function automatic logic capreg_is_top(input logic [MODE_W-1:0] m);
    return (m == 4'd8) || (m == 4'd10) || (m == 4'd12) || (m == 4'd14);
  endfunction

  function automatic logic plain_ovf_mode(input logic [MODE_W-1:0] m);
    return (m == 4'd0) || (m == 4'd4) || (m == 4'd12);
  endfunction
endpackage

// File: rtl/tmr_cmp_stage.sv
module tmr_cmp_stage #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cmp,
  input  logic          force_strobe,
  output logic          hit
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst)
      pend <= 1'b0;
    else if (tick)
      pend <= (cnt == cmp) && !force_strobe;
  end

  assign hit = tick && pend;

  // R6: a pending match only appears after a matching, unforced tick
  a_r6_pend_after_match: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(tick && (cnt == cmp) && !force_strobe));

  // R7: a forced tick never leaves a pending match
  a_r7_force_blocks: assert property (@(posedge clk) disable iff (rst)
    (tick && force_strobe) |=> !pend);
endmodule

// File: rtl/tmr_flag_bit.sv
module tmr_flag_bit (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (set)  q <= 1'b1;
    else if (clr)  q <= 1'b0;
  end

  // R3/R4: a clear with no competing set empties the flag
  a_r3_clear_takes: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !q);

  // R10: set wins over a simultaneous clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    set |=> q);
endmodule

// File: rtl/tmr_irq_gate.sv
module tmr_irq_gate #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         gie,
  input  logic [N-1:0] flag,
  input  logic [N-1:0] en,
  output logic [N-1:0] irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= '0;
    else     irq <= flag & en & {N{gie}};
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R5: request follows qualified flag by one cycle
    a_r5_irq_rise: assert property (@(posedge clk) disable iff (rst)
      (flag[i] && en[i] && gie) |=> irq[i]);
    a_r5_irq_fall: assert property (@(posedge clk) disable iff (rst)
      !(flag[i] && en[i] && gie) |=> !irq[i]);
  end
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tmr_irq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  cmp_a,
  input  logic [CNT_W-1:0]  cmp_b,
  input  logic              force_a,
  input  logic              force_b,
  input  logic              ovf_pulse,
  input  logic              wave_ovf_pulse,
  input  logic              cap_pulse,
  input  logic              top_pulse,
  input  logic [MODE_W-1:0] wmode,
  input  logic              gie,
  input  logic [NSRC-1:0]   ack,
  input  logic              flag_wr,
  input  logic              en_wr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  flag_q,
  output logic [REG_W-1:0]  en_q,
  output logic [NSRC-1:0]   irq
);
  logic [NSRC-1:0]  evt;
  logic [NSRC-1:0]  set_v;
  logic [NSRC-1:0]  clr_v;
  logic [NSRC-1:0]  flg;
  logic [NSRC-1:0]  en_src;
  logic [1:0]       cmp_hit;
  logic [REG_W-1:0] wr_live;

  assign wr_live = wdata & LIVE_MASK;

  // compare channels: identical stage per channel
  for (genvar c = 0; c < 2; c++) begin : g_cmp
    tmr_cmp_stage #(.CW(CNT_W)) i_stage (
      .clk          (clk),
      .rst          (rst),
      .tick         (tick),
      .cnt          (cnt),
      .cmp          ((c == 0) ? cmp_a : cmp_b),
      .force_strobe ((c == 0) ? force_a : force_b),
      .hit          (cmp_hit[c])
    );
  end

  always_comb begin
    evt[SRC_OVF]  = plain_ovf_mode(wmode) ? ovf_pulse : wave_ovf_pulse;
    evt[SRC_CMPA] = cmp_hit[0];
    evt[SRC_CMPB] = cmp_hit[1];
    evt[SRC_CAP]  = capreg_is_top(wmode) ? top_pulse : cap_pulse;
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam int P = src_pos(s);
    // compare hits are already tick-qualified
    assign set_v[s] = (s == SRC_CMPA || s == SRC_CMPB) ? evt[s] : (tick && evt[s]);
    assign clr_v[s] = (flag_wr && wr_live[P]) || ack[s];
    assign en_src[s] = en_q[P];

    tmr_flag_bit i_flag (
      .clk (clk),
      .rst (rst),
      .set (set_v[s]),
      .clr (clr_v[s]),
      .q   (flg[s])
    );
  end

  always_comb begin
    flag_q = '0;
    for (int s = 0; s < NSRC; s++)
      flag_q[src_pos(s)] = flg[s];
  end

  always_ff @(posedge clk) begin
    if (rst)         en_q <= '0;
    else if (en_wr)  en_q <= wr_live;
  end

  tmr_irq_gate #(.N(NSRC)) i_gate (
    .clk  (clk),
    .rst  (rst),
    .gie  (gie),
    .flag (flg),
    .en   (en_src),
    .irq  (irq)
  );

  // R8: TOP pulse sets capture flag in capture-as-TOP modes
  a_r8_top_sets_cap: assert property (@(posedge clk) disable iff (rst)
    (tick && top_pulse && capreg_is_top(wmode)) |=> flag_q[5]);

  // R9: plain wrap sets overflow flag in plain modes
  a_r9_ovf_plain: assert property (@(posedge clk) disable iff (rst)
    (tick && ovf_pulse && plain_ovf_mode(wmode)) |=> flag_q[0]);

  // R11: no flag rises from overflow or capture events without a tick
  a_r11_no_tick_no_set: assert property (@(posedge clk) disable iff (rst)
    !tick |=> !(flag_q[0] && !$past(flag_q[0])) && !(flag_q[5] && !$past(flag_q[5])));
endmodule

// File: tb/test_tmr_irq_flags.sv
module test_tmr_irq_flags;
  logic        clk = 1'b0;
  logic        rst;
  logic        tick;
  logic [15:0] cnt, cmp_a, cmp_b;
  logic        force_a, force_b;
  logic        ovf_pulse, wave_ovf_pulse, cap_pulse, top_pulse;
  logic [3:0]  wmode;
  logic        gie;
  logic [3:0]  ack;
  logic        flag_wr, en_wr;
  logic [7:0]  wdata;
  logic [7:0]  flag_q, en_q;
  logic [3:0]  irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  tmr_irq_flags i_tmr_irq_flags (
    .clk(clk), .rst(rst), .tick(tick), .cnt(cnt), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .force_a(force_a), .force_b(force_b), .ovf_pulse(ovf_pulse),
    .wave_ovf_pulse(wave_ovf_pulse), .cap_pulse(cap_pulse), .top_pulse(top_pulse),
    .wmode(wmode), .gie(gie), .ack(ack), .flag_wr(flag_wr), .en_wr(en_wr),
    .wdata(wdata), .flag_q(flag_q), .en_q(en_q), .irq(irq)
  );

  // {wmode, ovf, wave_ovf, cap, top, exp_ovf_flag, exp_cap_flag}  (R8, R9)
  localparam logic [9:0] VEC [12] = '{
    {4'd0,  4'b1000, 2'b10},
    {4'd0,  4'b0100, 2'b00},
    {4'd0,  4'b0010, 2'b01},
    {4'd0,  4'b0001, 2'b00},
    {4'd4,  4'b1000, 2'b10},
    {4'd12, 4'b1001, 2'b11},
    {4'd12, 4'b0010, 2'b00},
    {4'd14, 4'b1000, 2'b00},
    {4'd14, 4'b0101, 2'b11},
    {4'd5,  4'b0110, 2'b11},
    {4'd8,  4'b0001, 2'b01},
    {4'd10, 4'b0010, 2'b00}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    tick = 1'b1; cnt = 16'd0; force_a = 0; force_b = 0;
    ovf_pulse = 0; wave_ovf_pulse = 0; cap_pulse = 0; top_pulse = 0;
    ack = 4'd0; flag_wr = 0; en_wr = 0; wdata = 8'd0;
  endtask

  task automatic clear_all();
    flag_wr = 1; wdata = 8'hFF; step(); flag_wr = 0; wdata = 8'd0;
  endtask

  task automatic set_ovf_cap();
    wmode = 4'd0; ovf_pulse = 1; cap_pulse = 1; step();
    ovf_pulse = 0; cap_pulse = 0;
  endtask

  task automatic set_cmp_both();
    cmp_a = 16'd7; cmp_b = 16'd7; cnt = 16'd7; step();
    cnt = 16'd8; step();
    cmp_a = 16'h00FF; cmp_b = 16'h00FF; cnt = 16'd0;
  endtask

  initial begin
    rst = 1'b1; gie = 1'b0; wmode = 4'd0; cmp_a = 16'h00FF; cmp_b = 16'h00FF;
    idle();
    repeat (3) step();
    // R1 reset state
    chk("R1 flags", flag_q, 8'h00);
    chk("R1 enables", en_q, 8'h00);
    chk("R1 irq", irq, 4'h0);
    rst = 1'b0;
    step();

    // table walk: overflow and capture source by mode (R8, R9)
    for (int k = 0; k < 12; k++) begin
      clear_all();
      wmode = VEC[k][9:6];
      ovf_pulse = VEC[k][5]; wave_ovf_pulse = VEC[k][4];
      cap_pulse = VEC[k][3]; top_pulse = VEC[k][2];
      step();
      ovf_pulse = 0; wave_ovf_pulse = 0; cap_pulse = 0; top_pulse = 0;
      chk($sformatf("R9 ovf vec %0d", k), flag_q[0], VEC[k][1]);
      chk($sformatf("R8 cap vec %0d", k), flag_q[5], VEC[k][0]);
    end
    wmode = 4'd0;

    // R2 enable layout and reserved bits
    en_wr = 1; wdata = 8'hFF; step(); en_wr = 0;
    chk("R2 enable reserved", en_q, 8'h27);
    clear_all();
    set_ovf_cap(); set_cmp_both();
    chk("R2 flag layout", flag_q, 8'h27);

    // R3 write-one-to-clear
    flag_wr = 1; wdata = 8'h02; step(); flag_wr = 0;
    chk("R3 clear A only", flag_q, 8'h25);
    flag_wr = 1; wdata = 8'h00; step(); flag_wr = 0;
    chk("R3 zero write keeps", flag_q, 8'h25);

    // R4 acknowledge
    set_cmp_both();
    ack = 4'b0001; step(); chk("R4 ack ovf", flag_q, 8'h26);
    ack = 4'b0010; step(); chk("R4 ack A", flag_q, 8'h24);
    ack = 4'b0100; step(); chk("R4 ack B", flag_q, 8'h20);
    ack = 4'b1000; step(); chk("R4 ack cap", flag_q, 8'h00);
    ack = 4'b0000;

    // R6 compare latency of one tick
    cmp_a = 16'd5; cnt = 16'd5; step();
    chk("R6 not same tick", flag_q[1], 1'b0);
    cnt = 16'd6; step();
    chk("R6 next tick", flag_q[1], 1'b1);
    cmp_a = 16'h00FF; cnt = 16'd0; clear_all();

    // R7 forced strobe
    cmp_a = 16'd5; cmp_b = 16'd5; cnt = 16'd5; force_a = 1; force_b = 1; step();
    force_a = 0; force_b = 0; cnt = 16'd6; step(); step();
    chk("R7 forced no flag", flag_q[2:1], 2'b00);
    cmp_a = 16'h00FF; cmp_b = 16'h00FF; cnt = 16'd0;

    // R11 tick low ignores events
    tick = 0; ovf_pulse = 1; cap_pulse = 1; cmp_a = 16'd0; step();
    ovf_pulse = 0; cap_pulse = 0; cnt = 16'd1; step();
    tick = 1; step(); step();
    chk("R11 no tick", flag_q, 8'h00);
    cmp_a = 16'h00FF;

    // R10 set wins over clear and ack
    ovf_pulse = 1; flag_wr = 1; wdata = 8'h01; step();
    ovf_pulse = 0; flag_wr = 0;
    chk("R10 set beats write", flag_q[0], 1'b1);
    cap_pulse = 1; ack = 4'b1000; step();
    cap_pulse = 0; ack = 4'b0000;
    chk("R10 set beats ack", flag_q[5], 1'b1);
    clear_all();

    // R5 request timing and gating
    en_wr = 1; wdata = 8'h01; step(); en_wr = 0;
    gie = 1; ovf_pulse = 1; step(); ovf_pulse = 0;
    chk("R5 irq lags flag", irq, 4'h0);
    step();
    chk("R5 irq asserted", irq, 4'h1);
    gie = 0; step();
    chk("R5 gie off", irq, 4'h0);
    gie = 1; en_wr = 1; wdata = 8'h00; step(); en_wr = 0;
    step();
    chk("R5 enable off", irq, 4'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule